// File: doc/BRIEF.md
# Byte-to-Line Transmit Packet Engine

This block sits between a serial interface engine and a USB line driver on the transmit side. The sender raises a valid flag and offers one byte at a time. The engine accepts each byte under a ready/valid handshake and puts the synchronisation field in front of the first byte without being asked. It shifts every byte out least significant bit first, inserts stuffed zeros, and encodes the stream in NRZI form. When the sender has stopped offering bytes, it closes the packet with an end-of-packet sequence. Each pulse on a bit-time strobe produces one line symbol, so the strobe rate sets the signalling rate and the system clock may run faster.

The sender provides every packet byte itself: the PID, the payload and the CRC bytes. The engine computes no checksum. A mode input chooses among three behaviours: normal encoding, a raw mode that sends bits directly as line states (used for test patterns and resume signalling), and a non-driving mode that keeps the line released. The engine holds one byte in reserve. It lowers ready while that byte waits, so stuffed bits slow the sender down automatically.

Top module: `utmi_tx_engine`

## Requirements
- R1: After reset, and between packets, `driveEn` is 0, `lineSym` shows J (2'b01) and `txReady` is 0.
- R2: `lineSym` and `driveEn` change only at a clock edge where `bitStrobe` is 1. Each such strobe inside a packet produces exactly one bit time.
- R3: When the engine is idle, a high `txValid` with `opMode` other than 1 starts a packet, and `opMode` is sampled at that moment. A byte is taken only on a clock where `txValid` and `txReady` are both 1. The bytes sent on the line are exactly the bytes accepted, in the order they were accepted.
- R4: The engine holds at most one byte in reserve. On the clock after a byte is accepted, `txReady` is 0, and it stays 0 while a reserved byte waits, including the bit times spent on stuffed bits.
- R5: The first eight bit times of a packet carry the synchronisation data bits 0,0,0,0,0,0,0,1 in that order. In normal mode they appear as K J K J K J K K.
- R6: The bits of each byte go out least significant bit first.
- R7: In normal mode (`opMode` 0) the line starts from J. A 0 bit toggles the line between J (2'b01) and K (2'b10), and a 1 bit holds it.
- R8: In normal mode, a 0 bit is inserted after every six consecutive 1 data bits. The final 1 of the synchronisation field counts toward the run, and a run that ends on the last byte is still stuffed before end-of-packet.
- R9: In raw mode (`opMode` 2) no bits are stuffed and there is no NRZI. A 0 bit drives K and a 1 bit drives J.
- R10: After the last byte, the line carries SE0 (2'b00) for two bit times and then J for one bit time. `driveEn` falls at the next strobe.
- R11: Once `txValid` has been seen low during a packet, the bytes already accepted are still sent in full. `txReady` then stays 0 until the packet ends, even if `txValid` rises again.
- R12: In non-driving mode (`opMode` 1) the engine does not react to `txValid`: no packet starts, and `driveEn` and `txReady` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitStrobe | input | 1 | One-clock pulse marking each bit time |
| dataIn | input | 8 | Byte offered by the sender |
| txValid | input | 1 | Sender has a byte; frames the packet |
| opMode | input | 2 | 0 normal, 1 non-driving, 2 raw bits |
| txReady | output | 1 | Byte on dataIn is taken this clock if txValid is high |
| lineSym | output | 2 | Line state: 2'b00 SE0, 2'b01 J, 2'b10 K |
| driveEn | output | 1 | Line is being driven |

## Verification
The bench builds the engine with its default parameters: 8-bit bytes, a stuffing run of six, and two bit times of SE0. At these values a single 0xFC byte ends on exactly six ones, which brings the stuffed bit placed just before end-of-packet within reach. Runs of 0xFF bytes push several stuffed bits through and hold the reserve byte for longer. The strobe gaps range from none to three idle clocks. A gap of zero places a byte boundary on consecutive clocks, right next to the acceptance of the next byte.

// File: rtl/utx_pkg.sv
package utx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SEND,
    ST_EOP
  } txState_t;

  localparam logic [1:0] SYM_SE0 = 2'b00;
  localparam logic [1:0] SYM_J   = 2'b01;
  localparam logic [1:0] SYM_K   = 2'b10;

  localparam logic [1:0] OPM_NORMAL  = 2'd0;
  localparam logic [1:0] OPM_NODRIVE = 2'd1;
  localparam logic [1:0] OPM_RAW     = 2'd2;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;    // take dataIn into the reserve byte
    logic loadSync;   // preload the sync pattern, reset line level
    logic sendBit;    // emit next data bit
    logic sendStuff;  // emit a stuffed zero
    logic loadNext;   // move reserve byte into shifter (with sendBit)
    logic sendSe0;
    logic sendJ;
    logic dropDrive;
    logic rawMode;
  } txCmd_t;

  // status from datapath to control
  typedef struct packed {
    logic holdFull;
    logic lastBit;
    logic stuffDue;
  } dpStat_t;

endpackage

// File: rtl/utx_ctrl.sv
module utx_ctrl
  import utx_pkg::*;
#(
  parameter int EOP_SE0_BITS = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitStrobe,
  input  logic       txValid,
  input  logic [1:0] opMode,
  input  dpStat_t    stat,
  output txCmd_t     cmd,
  output logic       txReady,
  output logic       inEop
);

  localparam int EOP_W = $clog2(EOP_SE0_BITS + 2);
  localparam logic [EOP_W-1:0] EOP_J_STEP   = EOP_W'(EOP_SE0_BITS);

  txState_t         state, nextState;
  logic [EOP_W-1:0] eopCnt;
  logic             endSeen;
  logic             rawMode;
  logic             boundary;
  logic             startPkt;

  assign startPkt = (state == ST_IDLE) && txValid && (opMode != OPM_NODRIVE);
  assign boundary = bitStrobe && !stat.stuffDue && stat.lastBit;
  assign inEop    = (state == ST_EOP);

  always_comb begin
    cmd         = '0;
    cmd.rawMode = rawMode;
    nextState   = state;
    txReady     = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (startPkt) begin
          nextState    = ST_SEND;
          cmd.loadSync = 1'b1;
        end
      end
      ST_SEND: begin
        txReady     = !stat.holdFull && !endSeen && !boundary;
        cmd.capture = txValid && txReady;
        if (bitStrobe) begin
          if (stat.stuffDue) begin
            cmd.sendStuff = 1'b1;
          end else begin
            cmd.sendBit = 1'b1;
            if (stat.lastBit) begin
              if (stat.holdFull) cmd.loadNext = 1'b1;
              else               nextState    = ST_EOP;
            end
          end
        end
      end
      ST_EOP: begin
        if (bitStrobe) begin
          if (eopCnt == '0 && stat.stuffDue) begin
            cmd.sendStuff = 1'b1;
          end else if (eopCnt < EOP_J_STEP) begin
            cmd.sendSe0 = 1'b1;
          end else if (eopCnt == EOP_J_STEP) begin
            cmd.sendJ = 1'b1;
          end else begin
            cmd.dropDrive = 1'b1;
            nextState     = ST_IDLE;
          end
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      eopCnt  <= '0;
      endSeen <= 1'b0;
      rawMode <= 1'b0;
    end else begin
      state <= nextState;
      if (startPkt) begin
        rawMode <= (opMode == OPM_RAW);
        endSeen <= 1'b0;
        eopCnt  <= '0;
      end
      if (state == ST_SEND && !txValid) endSeen <= 1'b1;
      if (cmd.sendSe0 || cmd.sendJ) eopCnt <= eopCnt + 1'b1;
    end
  end

  AST_ONE_PENDING: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && txReady) |=> !txReady); // R4

  AST_END_LOCKS_READY: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SEND && !txValid) |=> !txReady); // R11

  AST_NODRIVE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && opMode == OPM_NODRIVE) |=> (state == ST_IDLE)); // R12

endmodule

// File: rtl/utx_datapath.sv
module utx_datapath
  import utx_pkg::*;
#(
  parameter int                BYTE_W       = 8,
  parameter int                STUFF_RUN    = 6,
  parameter logic [BYTE_W-1:0] SYNC_PATTERN = 8'h80
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [BYTE_W-1:0] dataIn,
  input  txCmd_t            cmd,
  output dpStat_t           stat,
  output logic [1:0]        lineSym,
  output logic              driveEn
);

  localparam int BIT_IDX_W = $clog2(BYTE_W);
  localparam int RUN_W     = $clog2(STUFF_RUN + 1);
  localparam logic [BIT_IDX_W-1:0] LAST_IDX = BIT_IDX_W'(BYTE_W - 1);
  localparam logic [RUN_W-1:0]     RUN_MAX  = RUN_W'(STUFF_RUN);

  logic [BYTE_W-1:0]    holdByte, shiftReg;
  logic                 holdFull;
  logic [BIT_IDX_W-1:0] bitIdx;
  logic [RUN_W-1:0]     onesCnt;
  logic                 lineIsJ;
  logic [1:0]           symReg;
  logic                 driveReg;
  logic                 dataBit, nrziLvl;

  assign dataBit       = shiftReg[0];
  assign nrziLvl       = dataBit ? lineIsJ : !lineIsJ;
  assign stat.holdFull = holdFull;
  assign stat.lastBit  = (bitIdx == LAST_IDX);
  assign stat.stuffDue = !cmd.rawMode && (onesCnt == RUN_MAX);
  assign lineSym       = symReg;
  assign driveEn       = driveReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdByte <= '0;
      shiftReg <= '0;
      holdFull <= 1'b0;
      bitIdx   <= '0;
      onesCnt  <= '0;
      lineIsJ  <= 1'b1;
      symReg   <= SYM_J;
      driveReg <= 1'b0;
    end else begin
      if (cmd.capture) begin
        holdByte <= dataIn;
        holdFull <= 1'b1;
      end
      if (cmd.loadSync) begin
        shiftReg <= SYNC_PATTERN;
        bitIdx   <= '0;
        onesCnt  <= '0;
        lineIsJ  <= 1'b1;
      end
      if (cmd.sendBit) begin
        driveReg <= 1'b1;
        if (cmd.rawMode) begin
          symReg <= dataBit ? SYM_J : SYM_K;
        end else begin
          symReg  <= nrziLvl ? SYM_J : SYM_K;
          lineIsJ <= nrziLvl;
          onesCnt <= dataBit ? onesCnt + 1'b1 : '0;
        end
        if (stat.lastBit) begin
          bitIdx <= '0;
          if (cmd.loadNext) begin
            shiftReg <= holdByte;
            holdFull <= 1'b0;
          end
        end else begin
          bitIdx   <= bitIdx + 1'b1;
          shiftReg <= shiftReg >> 1;
        end
      end
      if (cmd.sendStuff) begin
        driveReg <= 1'b1;
        symReg   <= lineIsJ ? SYM_K : SYM_J;
        lineIsJ  <= !lineIsJ;
        onesCnt  <= '0;
      end
      if (cmd.sendSe0) begin
        driveReg <= 1'b1;
        symReg   <= SYM_SE0;
      end
      if (cmd.sendJ) begin
        symReg <= SYM_J;
      end
      if (cmd.dropDrive) begin
        driveReg <= 1'b0;
        symReg   <= SYM_J;
        lineIsJ  <= 1'b1;
      end
    end
  end

  AST_RUN_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    onesCnt <= RUN_MAX); // R8

  AST_NO_LOAD_COLLIDE: assert property (@(posedge clk) disable iff (!rstN)
    !(cmd.capture && cmd.loadNext)); // R4

endmodule

// File: rtl/utmi_tx_engine.sv
module utmi_tx_engine
  import utx_pkg::*;
#(
  parameter int BYTE_W       = 8,
  parameter int STUFF_RUN    = 6,
  parameter int EOP_SE0_BITS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitStrobe,
  input  logic [BYTE_W-1:0] dataIn,
  input  logic              txValid,
  input  logic [1:0]        opMode,
  output logic              txReady,
  output logic [1:0]        lineSym,
  output logic              driveEn
);

  localparam logic [BYTE_W-1:0] SYNC_PATTERN = BYTE_W'(1) << (BYTE_W - 1);

  txCmd_t  cmd;
  dpStat_t stat;
  logic    inEop;

  utx_ctrl #(
    .EOP_SE0_BITS(EOP_SE0_BITS)
  ) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .bitStrobe(bitStrobe),
    .txValid  (txValid),
    .opMode   (opMode),
    .stat     (stat),
    .cmd      (cmd),
    .txReady  (txReady),
    .inEop    (inEop)
  );

  utx_datapath #(
    .BYTE_W      (BYTE_W),
    .STUFF_RUN   (STUFF_RUN),
    .SYNC_PATTERN(SYNC_PATTERN)
  ) dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .dataIn (dataIn),
    .cmd    (cmd),
    .stat   (stat),
    .lineSym(lineSym),
    .driveEn(driveEn)
  );

  AST_HOLD_BETWEEN_STROBES: assert property (@(posedge clk) disable iff (!rstN)
    !bitStrobe |=> ($stable(lineSym) && $stable(driveEn))); // R2

  AST_SE0_ONLY_IN_EOP: assert property (@(posedge clk) disable iff (!rstN)
    (lineSym == SYM_SE0) |-> inEop); // R10

  AST_RELEASED_IS_J: assert property (@(posedge clk) disable iff (!rstN)
    !driveEn |-> (lineSym == SYM_J)); // R1

endmodule

// File: tb/utmi_tx_engine_tb_top.sv
module utmi_tx_engine_tb_top;

  localparam logic [1:0] SE0 = 2'b00;
  localparam logic [1:0] SJ  = 2'b01;
  localparam logic [1:0] SK  = 2'b10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       bitStrobe = 1'b0;
  logic [7:0] dataIn = 8'h00;
  logic       txValid = 1'b0;
  logic [1:0] opMode = 2'd0;
  logic       txReady;
  logic [1:0] lineSym;
  logic       driveEn;

  always #2.5 clk = ~clk;

  utmi_tx_engine dut_i (
    .clk(clk), .rstN(rstN), .bitStrobe(bitStrobe), .dataIn(dataIn),
    .txValid(txValid), .opMode(opMode), .txReady(txReady),
    .lineSym(lineSym), .driveEn(driveEn)
  );

  int nChk = 0;
  int nBad = 0;

  logic [7:0] pktBytes [16];
  int         pktLen;
  logic [1:0] expSym [512];

  logic [7:0] accBytes [1024];
  int         accN = 0;
  logic [1:0] capSym [8192];
  int         capN = 0;
  logic       strobeD = 1'b0;
  logic       accD = 1'b0;
  int         r2Bad = 0;
  int         r4Bad = 0;
  logic [1:0] prevSym = 2'b01;
  logic       prevDrv = 1'b0;

  // acceptance monitor (pre-edge values equal the engine's view)
  always @(posedge clk) begin
    strobeD <= bitStrobe;
    accD    <= rstN && txValid && txReady;
    if (rstN && txValid && txReady) begin
      accBytes[accN % 1024] <= dataIn;
      accN <= accN + 1;
    end
  end

  // symbol capture and R2/R4 watchers
  always @(negedge clk) begin
    if (rstN) begin
      if (strobeD && driveEn) begin
        capSym[capN % 8192] <= lineSym;
        capN <= capN + 1;
      end
      if (!strobeD && (lineSym != prevSym || driveEn != prevDrv)) r2Bad <= r2Bad + 1;
      if (accD && txReady) r4Bad <= r4Bad + 1;
      prevSym <= lineSym;
      prevDrv <= driveEn;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int build_exp(input int mode);
    int   n = 0;
    int   ones = 0;
    logic lvl = 1'b1;
    logic b;
    for (int i = 0; i < 8 + 8 * pktLen; i++) begin
      b = (i < 8) ? (i == 7) : pktBytes[(i - 8) / 8][(i - 8) % 8];
      if (mode == 2) begin
        expSym[n] = b ? SJ : SK;
        n++;
      end else begin
        if (!b) lvl = !lvl;
        expSym[n] = lvl ? SJ : SK;
        n++;
        ones = b ? ones + 1 : 0;
        if (ones == 6) begin
          lvl = !lvl;
          expSym[n] = lvl ? SJ : SK;
          n++;
          ones = 0;
        end
      end
    end
    expSym[n]     = SE0;
    expSym[n + 1] = SE0;
    expSym[n + 2] = SJ;
    return n + 3;
  endfunction

  task automatic run_packet(input int mode, input int gapMax, input bit blip);
    int  base = accN;
    int  capBase = capN;
    int  k = 0;
    int  it = 0;
    int  dropAt = -1;
    int  gap = 0;
    int  n;
    int  firstBad;
    int  blipBad = 0;
    bit  saw = 0;
    bit  inBlip = 0;
    bit  okB;
    @(negedge clk);
    opMode  = 2'(mode);
    dataIn  = pktBytes[0];
    txValid = 1'b1;
    while (it < 6000) begin
      @(negedge clk);
      it++;
      if (inBlip && txReady) blipBad++;
      k = accN - base;
      inBlip = 0;
      if (k < pktLen) begin
        txValid = 1'b1;
        dataIn  = pktBytes[k];
      end else begin
        if (dropAt < 0) dropAt = it;
        if (blip && it >= dropAt + 2 && it < dropAt + 14) begin
          txValid = 1'b1;
          dataIn  = 8'hAA;
          inBlip  = 1;
        end else begin
          txValid = 1'b0;
        end
      end
      bitStrobe = (gap == 0);
      gap = (gap == 0) ? $urandom_range(gapMax, 0) : gap - 1;
      if (driveEn) saw = 1;
      if (saw && !driveEn && dropAt >= 0 && it > dropAt + 16) break;
    end
    bitStrobe = 1'b0;
    txValid   = 1'b0;
    repeat (3) @(negedge clk);

    k = accN - base;
    check(k == pktLen, "R3 accepted byte count", k, pktLen);
    okB = 1;
    for (int i = 0; i < pktLen && i < k; i++)
      if (accBytes[(base + i) % 1024] != pktBytes[i]) okB = 0;
    check(okB, "R3 accepted bytes in order", okB, 1);
    if (blip) check(blipBad == 0, "R11 txReady after txValid dropped", blipBad, 0);

    n = build_exp(mode);
    check(capN - capBase == n, "R8/R9 bit-time count", capN - capBase, n);
    firstBad = -1;
    for (int i = 0; i < 8; i++)
      if (firstBad < 0 && capSym[(capBase + i) % 8192] != expSym[i]) firstBad = i;
    check(firstBad < 0, "R5 sync field", firstBad, -1);
    firstBad = -1;
    for (int i = 0; i < n && i < capN - capBase; i++)
      if (firstBad < 0 && capSym[(capBase + i) % 8192] != expSym[i]) firstBad = i;
    if (mode == 2) check(firstBad < 0, "R9 raw bits R6 order", firstBad, -1);
    else           check(firstBad < 0, "R7 NRZI R8 stuffing R6 order", firstBad, -1);
    okB = (capN - capBase >= 3) &&
          capSym[(capN - 3) % 8192] == SE0 && capSym[(capN - 2) % 8192] == SE0 &&
          capSym[(capN - 1) % 8192] == SJ;
    check(okB, "R10 end-of-packet tail", okB, 1);
    check(!driveEn && lineSym == SJ && !txReady, "R1 idle after packet",
          {driveEn, lineSym, txReady}, 32'h2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", nChk + 1, nBad + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(!driveEn && lineSym == SJ && !txReady, "R1 reset state",
          {driveEn, lineSym, txReady}, 32'h2);

    // directed: run of six ones ends the packet -> stuff before EOP
    pktLen = 1; pktBytes[0] = 8'hFC;
    run_packet(0, 1, 0);
    // heavy stuffing, strobe every clock
    pktLen = 3; pktBytes[0] = 8'hFF; pktBytes[1] = 8'hFF; pktBytes[2] = 8'hFF;
    run_packet(0, 0, 0);
    // raw mode, no stuffing despite ones
    pktLen = 3; pktBytes[0] = 8'hFF; pktBytes[1] = 8'h00; pktBytes[2] = 8'h5A;
    run_packet(2, 2, 0);
    // all zeros
    pktLen = 2; pktBytes[0] = 8'h00; pktBytes[1] = 8'h00;
    run_packet(0, 3, 0);
    // R11: txValid drops then rises again mid-packet
    pktLen = 1; pktBytes[0] = 8'hC3;
    run_packet(0, 0, 1);

    // R12: non-driving mode ignores txValid
    begin
      int bad = 0;
      @(negedge clk);
      opMode = 2'd1; txValid = 1'b1; dataIn = 8'h55;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        bitStrobe = (i % 2 == 0);
        if (driveEn || txReady) bad++;
      end
      bitStrobe = 1'b0; txValid = 1'b0; opMode = 2'd0;
      repeat (2) @(negedge clk);
      check(bad == 0, "R12 non-driving mode stays quiet", bad, 0);
    end

    // constrained random packets
    for (int p = 0; p < 28; p++) begin
      int mode = ($urandom_range(3, 0) == 0) ? 2 : 0;
      pktLen = $urandom_range(10, 1);
      for (int i = 0; i < pktLen; i++) begin
        int sel = $urandom_range(3, 0);
        pktBytes[i] = (sel == 0) ? 8'hFF : (sel == 1) ? 8'h7F : 8'($urandom_range(255, 0));
      end
      run_packet(mode, $urandom_range(3, 0), 0);
    end

    check(r2Bad == 0, "R2 outputs change only on strobe", r2Bad, 0);
    check(r4Bad == 0, "R4 ready low after acceptance", r4Bad, 0);

    $display("  test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end

endmodule